// File: doc/BRIEF.md
# Reset Supervisor with Programmable Watchdog

This block produces the synchronous, active-high chip reset. It has two sources. The first is a digital low-voltage flag that an external comparator drives. The flag must stay high for a run of consecutive cycles before it counts, and the reset it causes is held for a fixed number of crystal cycles after the flag clears. The second source is a watchdog that counts pulses of a slow time base, nominally one every 0.25 s. The watchdog raises the same reset when it counts past a programmed number of periods.

Software drives an 8-bit control write port:
- bit 7 enables the watchdog;
- bit 6 is a clear strobe that stores nothing;
- bits 2:0 choose the timeout in periods.

Any chip reset returns the watchdog to its power-on state, which is disabled, code 0 and count 0. Every pin is a plain control pin with no handshake. A write takes effect on the clock edge at which `ctrl_wr` is sampled high.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `chip_rst` is 1. After `por_n` rises, `chip_rst` stays 1 and falls on the 144th clock edge after the release.
- R2: A run of fewer than 16 consecutive cycles with `lv_flag` sampled high never raises `chip_rst`.
- R3: When `lv_flag` is held high, `chip_rst` is still 0 after the 16th edge that samples it high, and is 1 after the 17th.
- R4: After `lv_flag` returns low, `chip_rst` stays 1 through the 143rd edge after the first edge that samples it low, and is 0 after the 144th.
- R5: After any reset the watchdog is disabled, so time-base ticks never raise `chip_rst`.
- R6: When enabled, the watchdog raises `chip_rst` at the edge that samples the N-th tick, with no effect from the earlier ticks. N is the value in control bits 2:0, except that code 0 gives N = 8.
- R7: A write with bit 6 set zeroes the tick count. If a tick arrives in the same cycle, the clear wins and that tick is not counted.
- R8: A write whose bits 2:0 differ from the current code zeroes the tick count.
- R9: A watchdog-caused reset lasts exactly 144 cycles and leaves the watchdog disabled.
- R10: Control writes made while `chip_rst` is 1 have no effect.
- R11: A write with bit 7 clear disables the watchdog and zeroes its count. A later enable with the same code counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lv_flag | input | 1 | Low-voltage flag from the comparator, synchronous to `clk` |
| tb_tick | input | 1 | One-cycle pulse per time-base period |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 7 enable, bit 6 clear, bits 2:0 timeout code |
| chip_rst | output | 1 | Chip reset, active high, registered |

## Verification
The bench builds the block with its default parameters: a 16-cycle low-voltage filter and a 144-cycle hold. At those values the filter edge (15 cycles versus 16) and the exact release edge of every stretched reset can be checked cycle for cycle in a short run. Because the time base is a pin, each timeout code, including code 0 and code 1, reaches overflow within a few dozen cycles. That also brings the clear-versus-tick collision and the code-change restart within reach.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned CLR_BIT = 6;
  localparam int unsigned CODE_W  = 3;

  typedef struct packed {
    logic              en;
    logic              clr;
    logic [CODE_W-1:0] code;
  } wd_ctrl_t;

  function automatic wd_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] d);
    wd_ctrl_t c;
    c.en   = d[EN_BIT];
    c.clr  = d[CLR_BIT];
    c.code = d[CODE_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/rst_sup_lv_filter.sv
module rst_sup_lv_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic lv_in,
  output logic lv_hit
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

  logic [CW-1:0] run_q;

  // count consecutive sampled-high cycles, saturate at FULL
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 run_q <= '0;
    else if (!lv_in)            run_q <= '0;
    else if (run_q != FULL)     run_q <= run_q + 1'b1;
  end

  assign lv_hit = (run_q == FULL);

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!por_n)
    run_q <= FULL);
  a_r2_low_drops_hit: assert property (@(posedge clk) disable iff (!por_n)
    !lv_in |=> !lv_hit);
endmodule

// File: rtl/rst_sup_stretch.sv
module rst_sup_stretch #(
  parameter int unsigned HOLD_CYC = 144
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] hold_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_q <= HOLD;
      rst_q  <= 1'b1;
    end else if (trig) begin
      hold_q <= HOLD;
      rst_q  <= 1'b1;
    end else begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      rst_q <= (hold_q > ONE);
    end
  end

  assign rst_o = rst_q;

  a_r4_trig_asserts: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> rst_o);
  a_r9_min_width: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_o) |=> rst_o);
  a_r4_release_quiet: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> $past(!trig));
endmodule

// File: rtl/rst_sup_wdog.sv
module rst_sup_wdog
  import rst_sup_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     chip_rst,
  input  logic     tick,
  input  logic     wr_en,
  input  wd_ctrl_t wr_ctrl,
  output logic     bite
);
  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] last_idx;
  logic              wr_ok;
  logic              restart;

  // code 0 wraps to all ones: eight periods
  assign last_idx = code_q - 1'b1;
  assign wr_ok    = wr_en & ~chip_rst;
  assign restart  = wr_ok & (wr_ctrl.clr | ~wr_ctrl.en | (wr_ctrl.code != code_q));
  assign bite     = en_q & tick & ~restart & ~chip_rst & (cnt_q == last_idx);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      cnt_q  <= '0;
    end else if (chip_rst || bite) begin
      en_q   <= 1'b0;
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) begin
        en_q   <= wr_ctrl.en;
        code_q <= wr_ctrl.code;
      end
      if (restart || !en_q) cnt_q <= '0;
      else if (tick)        cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_idle_no_bite: assert property (@(posedge clk) disable iff (!por_n)
    !en_q |-> !bite);
  a_r9_bite_disables: assert property (@(posedge clk) disable iff (!por_n)
    bite |=> (!en_q && cnt_q == '0));
  a_r10_rst_blocks: assert property (@(posedge clk) disable iff (!por_n)
    chip_rst |=> !en_q);
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !chip_rst && wr_ctrl.clr) |=> cnt_q == '0);
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= last_idx);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned LV_FILT_LEN = 16,
  parameter int unsigned HOLD_CYC    = 144
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              lv_flag,
  input  logic              tb_tick,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              chip_rst
);
  logic     lv_hit;
  logic     wd_bite;
  logic     rst_int;
  wd_ctrl_t ctrl;
  logic     unused_rsvd;

  assign ctrl        = decode_ctrl(ctrl_wdata);
  assign unused_rsvd = ^ctrl_wdata[CLR_BIT-1:CODE_W];

  rst_sup_lv_filter #(.FILT_LEN(LV_FILT_LEN)) u_lv (
    .clk   (clk),
    .por_n (por_n),
    .lv_in (lv_flag),
    .lv_hit(lv_hit)
  );

  rst_sup_wdog u_wd (
    .clk     (clk),
    .por_n   (por_n),
    .chip_rst(rst_int),
    .tick    (tb_tick),
    .wr_en   (ctrl_wr),
    .wr_ctrl (ctrl),
    .bite    (wd_bite)
  );

  rst_sup_stretch #(.HOLD_CYC(HOLD_CYC)) u_st (
    .clk  (clk),
    .por_n(por_n),
    .trig (lv_hit | wd_bite),
    .rst_o(rst_int)
  );

  assign chip_rst = rst_int;

  a_r3_lv_to_rst: assert property (@(posedge clk) disable iff (!por_n)
    lv_hit |=> chip_rst);
  a_r6_bite_to_rst: assert property (@(posedge clk) disable iff (!por_n)
    wd_bite |=> chip_rst);
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  timeunit 1ns; timeprecision 1ps;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 50000;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       lv_flag = 1'b0;
  logic       tb_tick = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       chip_rst;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  int    q_at[$];
  logic  q_val[$];
  string q_tag[$];

  rst_supervisor uut (
    .clk(clk), .por_n(por_n), .lv_flag(lv_flag), .tb_tick(tb_tick),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .chip_rst(chip_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: chip_rst=%b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop scoreboard items when their cycle arrives
  always @(negedge clk) begin
    while (q_at.size() > 0 && q_at[0] <= cyc) begin
      check(chip_rst, q_val[0], q_tag[0]);
      void'(q_at.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic expect_rst(input int dly, input logic v, input string tag);
    q_at.push_back(cyc + dly);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_at.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic tick(input logic bite, input string tag);
    @(negedge clk); tb_tick = 1'b1; expect_rst(1, bite, tag);
    @(negedge clk); tb_tick = 1'b0;
  endtask

  task automatic ticks_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, tag);
  endtask

  // called right after the biting tick: cyc equals the bite edge
  task automatic wd_window(input string tag);
    expect_rst(143, 1'b1, tag);
    expect_rst(144, 1'b0, tag);
    drain();
  endtask

  task automatic run_all();
    // R1 power-on
    idle(3);
    check(chip_rst, 1'b1, "R1 during por");
    @(negedge clk); por_n = 1'b1;
    expect_rst(1, 1'b1, "R1 held");
    expect_rst(143, 1'b1, "R1 held last");
    expect_rst(144, 1'b0, "R1 release");
    drain();

    // R2 15-cycle glitch
    @(negedge clk); lv_flag = 1'b1;
    for (int k = 1; k <= 15; k++) expect_rst(k, 1'b0, "R2 glitch");
    idle(15); lv_flag = 1'b0;
    for (int k = 1; k <= 5; k++) expect_rst(k, 1'b0, "R2 glitch after");
    drain();

    // R3 / R4 low-voltage reset and release
    @(negedge clk); lv_flag = 1'b1;
    expect_rst(16, 1'b0, "R3 before filter");
    expect_rst(17, 1'b1, "R3 asserted");
    idle(30); lv_flag = 1'b0;
    expect_rst(144, 1'b1, "R4 still held");
    expect_rst(145, 1'b0, "R4 release");
    drain();

    // R5 disabled after reset
    ticks_quiet(10, "R5 disabled");

    // R6 code 3, R9 window and enable cleared
    wr_reg(8'h83);
    ticks_quiet(2, "R6 code3 early");
    tick(1'b1, "R6 code3 overflow");
    wd_window("R9 wd pulse");
    ticks_quiet(9, "R9 enable cleared");

    // R6 code 0 = eight, R10 write during reset
    wr_reg(8'h80);
    ticks_quiet(7, "R6 code0 early");
    tick(1'b1, "R6 code0 overflow");
    expect_rst(143, 1'b1, "R9 wd pulse");
    expect_rst(144, 1'b0, "R9 wd pulse");
    idle(10);
    wr_reg(8'h81);
    drain();
    ticks_quiet(3, "R10 write in reset ignored");

    // R6 code 1
    wr_reg(8'h81);
    tick(1'b1, "R6 code1 overflow");
    wd_window("R9 wd pulse");

    // R7 clear strobe
    wr_reg(8'h84);
    ticks_quiet(3, "R7 pre");
    wr_reg(8'hC4);
    ticks_quiet(3, "R7 after clear");
    tick(1'b1, "R7 overflow");
    wd_window("R9 wd pulse");

    // R7 clear beats tick
    wr_reg(8'h82);
    ticks_quiet(1, "R7 pre");
    @(negedge clk); tb_tick = 1'b1; ctrl_wr = 1'b1; ctrl_wdata = 8'hC2;
    expect_rst(1, 1'b0, "R7 clear beats tick");
    @(negedge clk); tb_tick = 1'b0; ctrl_wr = 1'b0;
    ticks_quiet(1, "R7 after collision");
    tick(1'b1, "R7 overflow");
    wd_window("R9 wd pulse");

    // R8 code change restarts
    wr_reg(8'h85);
    ticks_quiet(4, "R8 pre");
    wr_reg(8'h87);
    ticks_quiet(6, "R8 restarted");
    tick(1'b1, "R8 overflow");
    wd_window("R9 wd pulse");

    // R11 disable and re-enable
    wr_reg(8'h83);
    ticks_quiet(2, "R11 pre");
    wr_reg(8'h03);
    ticks_quiet(5, "R11 disabled");
    wr_reg(8'h83);
    ticks_quiet(2, "R11 from zero");
    tick(1'b1, "R11 overflow");
    wd_window("R9 wd pulse");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected < %0d", cyc, WATCHDOG_CYC);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule